// File: doc/BRIEF.md
# Grouped Message Interrupt Aggregator

This block collects two kinds of interrupt events and folds them into a single interrupt line towards the processor. The first kind is the message-signalled interrupt. Each event names one of eight groups and one of 32 vectors inside that group, and it is latched in a per-group pending register. The second kind is the emulated legacy line interrupt. It arrives as assert and deassert messages for one of four lines, and the block tracks each line as a level. Message decoding from the link happens upstream. This block sees only the already decoded group/vector pair or the line/polarity pair, each on a valid/ready stream.

Software works through a simple word-addressed register port. Each group has a pending register, cleared by writing one to a bit, and a vector mask register. A group-enable register gates whole groups. A top-level cause register holds one summary bit per group and one bit per legacy line. A top-level enable register, with the same layout, selects which causes drive the output line. The summary bit of a group is sticky: it is cleared by writing one to it after the group has been drained. If the group still has unmasked pending vectors, the bit comes back.

Both event streams always accept. `msi_ready` and `intx_ready` are held high, so a beat transfers in every cycle in which its valid is high. No back-pressure is ever applied, and the upstream decoder needs no buffering for this block.

Top module: `irq_msg_aggregator`

## Requirements
- R1: A beat with `msi_valid` high sets bit `msi_vec` of the pending register of group `msi_group` (register address 16+2*group) at the clock edge that accepts it, and `msi_ready` is always 1.
- R2: Writing a pending register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R3: A beat that arrives in the same cycle as a write-one clear of the same pending bit wins, and the bit stays set.
- R4: Top-level cause bit 8+g sets one cycle after group g has a pending bit whose mask bit (address 17+2*g) is 1, and only while bit g of the group-enable register (address 2, bits 7..0) is 1. A masked vector or a disabled group leaves the cause bit clear.
- R5: Writing 1 to cause bit 8+g (address 0) clears it once the group has no unmasked pending bits. While unmasked pending bits remain, the bit stays set.
- R6: An assert message (`intx_assert`=1) for line L (0..3) sets cause bit 24+L. A write-one clear of that bit has no effect while the line is still asserted.
- R7: After a deassert message for line L, cause bit 24+L stays set until a write-one clear, which then clears it.
- R8: `irq_out` is the registered OR over cause bits that are set in the top-level enable register (address 1, same bit layout). It follows the causes by one cycle.
- R9: After reset, all pending, mask, enable and cause registers read 0, and `irq_out` is 0.
- R10: Read data appears on `reg_rdata` in the cycle after a read strobe. Unmapped addresses and unused bit positions read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msi_valid | input | 1 | Message interrupt beat valid |
| msi_ready | output | 1 | Always 1: beats are never stalled |
| msi_group | input | 3 | Group index of the beat |
| msi_vec | input | 5 | Vector index inside the group |
| intx_valid | input | 1 | Legacy line message valid |
| intx_ready | output | 1 | Always 1 |
| intx_line | input | 2 | Line 0..3 |
| intx_assert | input | 1 | 1 = assert message, 0 = deassert message |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after a read strobe |
| irq_out | output | 1 | Combined interrupt line |

## Verification
A message beat driven before edge 1 lands in its pending register at edge 1, in the group cause bit at edge 2 and on `irq_out` at edge 3. A legacy message reaches its cause bit at edge 1 and `irq_out` at edge 2. Register writes act at the edge that samples them, and reads return the state at the edge that samples the strobe. The bench therefore inserts idle cycles before reading a cause bit that depends on a pending or mask change. It samples `irq_out` on falling edges counted from the driving edge, checking it low after the first and second edges and high after the third. Same-cycle races are built by driving the beat and the clearing write on the same falling edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int GROUPS_DEF    = 8;
  localparam int VECS_DEF      = 32;
  localparam int LINES_DEF     = 4;
  localparam int AW_DEF        = 6;
  localparam int DW_DEF        = 32;
  localparam int CAUSE_GRP_LSB = 8;
  localparam int CAUSE_LIN_LSB = 24;
  localparam int A_CAUSE       = 0;
  localparam int A_CAUSE_EN    = 1;
  localparam int A_GROUP_EN    = 2;
  localparam int A_GROUP_BASE  = 16;
endpackage

// File: rtl/irq_msi_bank.sv
module irq_msi_bank #(
  parameter int VECS = 32,
  localparam int VECW = $clog2(VECS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  input  logic [VECW-1:0] hit_vec,
  input  logic            clr_we,
  input  logic            mask_we,
  input  logic [VECS-1:0] wdata,
  output logic [VECS-1:0] pend_o,
  output logic [VECS-1:0] mask_o,
  output logic            live_o
);
  logic [VECS-1:0] pend_q, mask_q, hit_bits, clr_bits;

  assign hit_bits = hit ? (VECS'(1) << hit_vec) : '0;
  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_bits) | hit_bits;
      if (mask_we) mask_q <= wdata;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign live_o = |(pend_q & mask_q);

  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend_q[$past(hit_vec)]);
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !hit) |=> ((pend_q & $past(wdata)) == '0));
endmodule

// File: rtl/irq_line_tracker.sv
module irq_line_tracker #(
  parameter int LINES = 4,
  localparam int LW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  logic [LW-1:0]    msg_line,
  input  logic             msg_assert,
  input  logic [LINES-1:0] clr,
  output logic [LINES-1:0] cause_o
);
  logic [LINES-1:0] level_q, level_d, cause_q;

  always_comb begin
    level_d = level_q;
    if (msg_valid) level_d[msg_line] = msg_assert;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      cause_q <= '0;
    end else begin
      level_q <= level_d;
      cause_q <= level_d | (cause_q & ~clr);
    end
  end

  assign cause_o = cause_q;

  for (genvar i = 0; i < LINES; i++) begin : g_chk
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (level_q[i] && !(msg_valid && msg_line == LW'(i) && !msg_assert))
      |=> cause_q[i]);
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_q[i] && clr[i] && !(msg_valid && msg_line == LW'(i) && msg_assert))
      |=> !cause_q[i]);
  end
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit #(
  parameter int GROUPS = 8,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GROUPS-1:0] grp_live,
  input  logic [LINES-1:0]  line_cause,
  input  logic [GROUPS-1:0] grp_clr,
  input  logic              en_we,
  input  logic [GROUPS-1:0] en_grp_wd,
  input  logic [LINES-1:0]  en_line_wd,
  input  logic              gen_we,
  input  logic [GROUPS-1:0] gen_wd,
  output logic [GROUPS-1:0] grp_cause_o,
  output logic [GROUPS-1:0] en_grp_o,
  output logic [LINES-1:0]  en_line_o,
  output logic [GROUPS-1:0] gen_o,
  output logic              irq_o
);
  logic [GROUPS-1:0] cause_q, en_grp_q, gen_q, feed;
  logic [LINES-1:0]  en_line_q;
  logic              irq_q, active;

  assign feed   = grp_live & gen_q;
  assign active = (|(cause_q & en_grp_q)) | (|(line_cause & en_line_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q   <= '0;
      en_grp_q  <= '0;
      en_line_q <= '0;
      gen_q     <= '0;
      irq_q     <= 1'b0;
    end else begin
      cause_q <= (cause_q & ~grp_clr) | feed;
      if (en_we) begin
        en_grp_q  <= en_grp_wd;
        en_line_q <= en_line_wd;
      end
      if (gen_we) gen_q <= gen_wd;
      irq_q <= active;
    end
  end

  assign grp_cause_o = cause_q;
  assign en_grp_o    = en_grp_q;
  assign en_line_o   = en_line_q;
  assign gen_o       = gen_q;
  assign irq_o       = irq_q;

  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    p_summary_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_live[g] && gen_q[g]) |=> cause_q[g]);
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_q[g] && !grp_clr[g]) |=> cause_q[g]);
  end
endmodule

// File: rtl/irq_msg_aggregator.sv
module irq_msg_aggregator
  import irq_agg_pkg::*;
#(
  parameter int GROUPS = GROUPS_DEF,
  parameter int VECS   = VECS_DEF,
  parameter int LINES  = LINES_DEF,
  parameter int AW     = AW_DEF,
  parameter int DW     = DW_DEF,
  localparam int GW    = $clog2(GROUPS),
  localparam int VW    = $clog2(VECS),
  localparam int LW    = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          msi_valid,
  output logic          msi_ready,
  input  logic [GW-1:0] msi_group,
  input  logic [VW-1:0] msi_vec,
  input  logic          intx_valid,
  output logic          intx_ready,
  input  logic [LW-1:0] intx_line,
  input  logic          intx_assert,
  input  logic          reg_en,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_out
);
  logic [VECS-1:0]   pend [GROUPS];
  logic [VECS-1:0]   mask [GROUPS];
  logic [GROUPS-1:0] live, grp_cause, en_grp, gen;
  logic [LINES-1:0]  line_cause, en_line, line_clr;
  logic [GROUPS-1:0] grp_clr;
  logic              wr, cause_wr;
  logic [DW-1:0]     cause_word, en_word, rd_d, rdata_q;

  assign msi_ready  = 1'b1;
  assign intx_ready = 1'b1;
  assign wr         = reg_en && reg_we;
  assign cause_wr   = wr && (reg_addr == AW'(A_CAUSE));
  assign grp_clr    = cause_wr ? reg_wdata[CAUSE_GRP_LSB +: GROUPS] : '0;
  assign line_clr   = cause_wr ? reg_wdata[CAUSE_LIN_LSB +: LINES] : '0;

  for (genvar g = 0; g < GROUPS; g++) begin : g_bank
    irq_msi_bank #(.VECS(VECS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (msi_valid && (msi_group == GW'(g))),
      .hit_vec (msi_vec),
      .clr_we  (wr && (reg_addr == AW'(A_GROUP_BASE + 2*g))),
      .mask_we (wr && (reg_addr == AW'(A_GROUP_BASE + 2*g + 1))),
      .wdata   (reg_wdata[VECS-1:0]),
      .pend_o  (pend[g]),
      .mask_o  (mask[g]),
      .live_o  (live[g])
    );
  end

  irq_line_tracker #(.LINES(LINES)) u_lines (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_valid  (intx_valid),
    .msg_line   (intx_line),
    .msg_assert (intx_assert),
    .clr        (line_clr),
    .cause_o    (line_cause)
  );

  irq_cause_unit #(.GROUPS(GROUPS), .LINES(LINES)) u_cause (
    .clk         (clk),
    .rst_n       (rst_n),
    .grp_live    (live),
    .line_cause  (line_cause),
    .grp_clr     (grp_clr),
    .en_we       (wr && (reg_addr == AW'(A_CAUSE_EN))),
    .en_grp_wd   (reg_wdata[CAUSE_GRP_LSB +: GROUPS]),
    .en_line_wd  (reg_wdata[CAUSE_LIN_LSB +: LINES]),
    .gen_we      (wr && (reg_addr == AW'(A_GROUP_EN))),
    .gen_wd      (reg_wdata[GROUPS-1:0]),
    .grp_cause_o (grp_cause),
    .en_grp_o    (en_grp),
    .en_line_o   (en_line),
    .gen_o       (gen),
    .irq_o       (irq_out)
  );

  always_comb begin
    cause_word = '0;
    cause_word[CAUSE_GRP_LSB +: GROUPS] = grp_cause;
    cause_word[CAUSE_LIN_LSB +: LINES]  = line_cause;
    en_word = '0;
    en_word[CAUSE_GRP_LSB +: GROUPS] = en_grp;
    en_word[CAUSE_LIN_LSB +: LINES]  = en_line;
  end

  always_comb begin
    rd_d = '0;
    if (reg_addr == AW'(A_CAUSE))    rd_d = cause_word;
    if (reg_addr == AW'(A_CAUSE_EN)) rd_d = en_word;
    if (reg_addr == AW'(A_GROUP_EN)) rd_d = DW'(gen);
    for (int g = 0; g < GROUPS; g++) begin
      if (reg_addr == AW'(A_GROUP_BASE + 2*g))     rd_d = DW'(pend[g]);
      if (reg_addr == AW'(A_GROUP_BASE + 2*g + 1)) rd_d = DW'(mask[g]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rdata_q <= '0;
    else if (reg_en && !reg_we) rdata_q <= rd_d;
  end

  assign reg_rdata = rdata_q;

  p_irq_reset_r9: assert property (@(posedge clk) $fell(rst_n) |-> !irq_out);
endmodule

// File: tb/irq_msg_aggregator_tb.sv
module irq_msg_aggregator_tb;
  logic clk = 0, rst_n = 0;
  logic msi_valid = 0, intx_valid = 0, intx_assert = 0;
  logic [2:0] msi_group = 0;
  logic [4:0] msi_vec = 0;
  logic [1:0] intx_line = 0;
  logic reg_en = 0, reg_we = 0;
  logic [5:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, rv;
  logic msi_ready, intx_ready, irq_out;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [5:0] CAUSE = 0, CAUSE_EN = 1, GROUP_EN = 2;
  localparam logic [31:0] EN_ALL = 32'h0F00_FF00;

  always #5 clk = ~clk;

  irq_msg_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_ready(msi_ready),
    .msi_group(msi_group), .msi_vec(msi_vec), .intx_valid(intx_valid),
    .intx_ready(intx_ready), .intx_line(intx_line), .intx_assert(intx_assert),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out));

  function automatic logic [5:0] pend_a(int g); return 6'(16 + 2*g); endfunction
  function automatic logic [5:0] mask_a(int g); return 6'(17 + 2*g); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_en = 0; reg_we = 0;
  endtask

  task automatic reg_rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_en = 1; reg_we = 0; reg_addr = a;
    @(negedge clk); reg_en = 0; d = reg_rdata;
  endtask

  task automatic send_msi(int g, int v);
    @(negedge clk); msi_valid = 1; msi_group = 3'(g); msi_vec = 5'(v);
    @(negedge clk); msi_valid = 0;
    idle(2);
  endtask

  task automatic send_intx(int l, bit a);
    @(negedge clk); intx_valid = 1; intx_line = 2'(l); intx_assert = a;
    @(negedge clk); intx_valid = 0;
    idle(1);
  endtask

  task automatic t_reset;
    reg_rd(CAUSE, rv);    chk("R9 cause after reset", rv, 0);
    reg_rd(pend_a(0), rv); chk("R9 pending after reset", rv, 0);
    reg_rd(CAUSE_EN, rv); chk("R9 enable after reset", rv, 0);
    chk("R9 irq after reset", 32'(irq_out), 0);
  endtask

  task automatic t_setup;
    reg_wr(GROUP_EN, 32'hBF);
    reg_wr(CAUSE_EN, EN_ALL);
    for (int g = 0; g < 8; g++) reg_wr(mask_a(g), (g == 5) ? 32'h0 : 32'hFFFF_FFFF);
    reg_rd(GROUP_EN, rv); chk("R10 group enable readback", rv, 32'hBF);
    reg_rd(CAUSE_EN, rv); chk("R10 cause enable unused bits zero", rv, EN_ALL);
    reg_rd(6'h3F, rv);    chk("R10 unmapped address", rv, 0);
  endtask

  task automatic t_capture;
    chk("R1 msi_ready high", 32'(msi_ready), 1);
    send_msi(2, 5);
    reg_rd(pend_a(2), rv); chk("R1 pending bit set", rv, 32'h20);
    reg_rd(pend_a(3), rv); chk("R1 other group untouched", rv, 0);
  endtask

  task automatic t_summary;
    reg_rd(CAUSE, rv); chk("R4 group 2 cause", rv, 32'h400);
    send_msi(5, 1);
    reg_rd(pend_a(5), rv); chk("R4 masked vector still pends", rv, 32'h2);
    reg_rd(CAUSE, rv); chk("R4 masked vector no cause", rv, 32'h400);
    send_msi(6, 3);
    reg_rd(CAUSE, rv); chk("R4 disabled group no cause", rv, 32'h400);
  endtask

  task automatic t_clear;
    reg_wr(pend_a(2), 32'h0);
    reg_rd(pend_a(2), rv); chk("R2 zero write keeps bit", rv, 32'h20);
    reg_wr(pend_a(2), 32'h20);
    reg_rd(pend_a(2), rv); chk("R2 one write clears bit", rv, 0);
    reg_rd(CAUSE, rv); chk("R5 cause sticky after drain", rv, 32'h400);
    reg_wr(CAUSE, 32'h400);
    reg_rd(CAUSE, rv); chk("R5 cause cleared after drain", rv, 0);
    chk("R8 irq low when no cause", 32'(irq_out), 0);
  endtask

  task automatic t_irq_timing;
    @(negedge clk); msi_valid = 1; msi_group = 0; msi_vec = 0;
    @(negedge clk); msi_valid = 0; chk("R8 irq low after edge 1", 32'(irq_out), 0);
    @(negedge clk); chk("R8 irq low after edge 2", 32'(irq_out), 0);
    @(negedge clk); chk("R8 irq high after edge 3", 32'(irq_out), 1);
    reg_wr(pend_a(0), 32'h1);
    reg_wr(CAUSE, 32'h100);
    idle(1);
    chk("R8 irq low after clear", 32'(irq_out), 0);
  endtask

  task automatic t_reassert;
    reg_wr(mask_a(5), 32'h2);
    idle(2);
    reg_rd(CAUSE, rv); chk("R4 unmasking raises cause", rv, 32'h2000);
    reg_wr(CAUSE, 32'h2000);
    reg_rd(CAUSE, rv); chk("R5 cause reasserts while pending", rv, 32'h2000);
    reg_wr(pend_a(5), 32'h2);
    reg_wr(CAUSE, 32'h2000);
    reg_rd(CAUSE, rv); chk("R5 cause clears once drained", rv, 0);
  endtask

  task automatic t_race;
    send_msi(3, 7);
    @(negedge clk);
    msi_valid = 1; msi_group = 3; msi_vec = 7;
    reg_en = 1; reg_we = 1; reg_addr = pend_a(3); reg_wdata = 32'h80;
    @(negedge clk);
    msi_valid = 0; reg_en = 0; reg_we = 0;
    reg_rd(pend_a(3), rv); chk("R3 arrival beats clear", rv, 32'h80);
    reg_wr(pend_a(3), 32'h80);
    reg_rd(pend_a(3), rv); chk("R3 plain clear works", rv, 0);
    reg_wr(CAUSE, 32'h800);
    reg_rd(CAUSE, rv); chk("R5 cause empty after race cleanup", rv, 0);
  endtask

  task automatic t_intx;
    send_intx(1, 1);
    reg_rd(CAUSE, rv); chk("R6 line cause set", rv, 32'h0200_0000);
    chk("R8 irq from line", 32'(irq_out), 1);
    reg_wr(CAUSE, 32'h0200_0000);
    reg_rd(CAUSE, rv); chk("R6 clear ignored while asserted", rv, 32'h0200_0000);
    send_intx(1, 0);
    reg_rd(CAUSE, rv); chk("R7 held after deassert", rv, 32'h0200_0000);
    reg_wr(CAUSE, 32'h0200_0000);
    reg_rd(CAUSE, rv); chk("R7 clear after deassert", rv, 0);
  endtask

  task automatic t_enable;
    reg_wr(CAUSE_EN, 32'h0700_FF00);
    send_intx(3, 1);
    idle(1);
    chk("R8 disabled line keeps irq low", 32'(irq_out), 0);
    reg_rd(CAUSE, rv); chk("R6 disabled line still captured", rv, 32'h0800_0000);
    reg_wr(CAUSE_EN, EN_ALL);
    idle(1);
    chk("R8 enabling raises irq", 32'(irq_out), 1);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    t_reset;
    t_setup;
    t_capture;
    t_summary;
    t_clear;
    t_irq_timing;
    t_reassert;
    t_race;
    t_intx;
    t_enable;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule